// File: doc/BRIEF.md
# Precision-Time Frame Stamp Latch

This block holds one hardware timestamp per traffic direction for a precision-time-protocol capable port. Upstream logic decodes each frame and presents a start-of-frame strobe together with a few fields: the ethertype, the UDP destination port, the protocol version and the message type. The block compares those fields against its configuration. When a frame qualifies, it copies the free-running 64-bit time counter into that direction's stamp register in the cycle of the strobe and raises that direction's valid flag.

Each direction then stays locked. Later frames are ignored until software has taken the stamp by reading the low 32-bit word and then the high 32-bit word. Reading the high word releases the lock. Clearing a direction's enable also releases it. On the transmit side only frames flagged by the sender as needing a stamp are eligible, so at most one transmit stamp is pending at any time.

On the receive side two qualifier settings are available. The first accepts version-1 frames carried over UDP to the configured event port whose message type equals a programmed value. The second accepts every version-2 event message, including the peer-delay ones. Such a message may arrive over UDP to the event port, or as a layer-2 frame whose ethertype hits an ethertype filter entry that has both its enable and its stamp bits set.

Top module: `ptp_stamp_latch`

## Requirements
- R1: While `rst` is high, `tx_valid`, `rx_valid` and `rd_data` are all zero.
- R2: A transmit stamp is taken when `tx_sof`, `tx_stamp_req` and `tx_en` are high and `tx_valid` is low. The stamp holds the `time_now` value present in that cycle, and `tx_valid` is high from the next cycle on.
- R3: While a direction's valid flag is high, further start-of-frame strobes in that direction leave its stamp unchanged and its flag set.
- R4: A read with `rd_sel[0]`=1 (high word) releases the selected direction, and its valid flag is low in the next cycle. A read with `rd_sel[0]`=0 (low word) leaves the flag unchanged.
- R5: `rd_sel` selects the word: 2'b00 is transmit low (stamp bits 31:0), 2'b01 is transmit high (bits 63:32), 2'b10 is receive low and 2'b11 is receive high. `rd_data` shows the chosen word in the cycle after `rd_en` and holds its value while `rd_en` is low.
- R6: With `rx_qual_mode`=0, a receive frame is stamped only if `rx_is_udp`=1, `rx_udp_dport` equals `cfg_event_port`, `rx_ptp_ver`=1 and `rx_msg_type` equals `cfg_v1_msg`.
- R7: With `rx_qual_mode`=1, a receive frame is stamped when `rx_ptp_ver`=2, `rx_msg_type` is in 0..3 (path-delay types 2 and 3 included) and the frame arrives either over UDP to `cfg_event_port` or as a layer-2 frame whose `rx_ethertype` equals `l2f_etype`. Message types of 4 and above are not stamped.
- R8: A layer-2 frame is never stamped unless both `l2f_en` and `l2f_stamp` are high.
- R9: While a direction's enable is low, no stamp is taken in that direction and its valid flag is low from the cycle after the enable falls.
- R10: When a high-word read of a locked direction and a qualifying start-of-frame fall in the same cycle, the frame is not stamped, the old stamp is kept and the flag is low afterwards.
- R11: A transmit start-of-frame with `tx_stamp_req` low is not stamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Free-running time counter |
| tx_en | input | 1 | Transmit stamping enable |
| rx_en | input | 1 | Receive stamping enable |
| rx_qual_mode | input | 1 | 0: version-1 UDP with message match, 1: all version-2 events |
| cfg_event_port | input | 16 | UDP event port to match (normally 319) |
| cfg_v1_msg | input | 4 | Version-1 message type to match |
| l2f_etype | input | 16 | Ethertype of the layer-2 filter entry (normally 0x88F7) |
| l2f_en | input | 1 | Layer-2 filter entry enable |
| l2f_stamp | input | 1 | Layer-2 filter entry stamp bit |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_stamp_req | input | 1 | Current transmit frame needs a stamp |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_is_l2 | input | 1 | Receive frame is a layer-2 frame |
| rx_ethertype | input | 16 | Decoded ethertype |
| rx_is_udp | input | 1 | Receive frame is UDP |
| rx_udp_dport | input | 16 | Decoded UDP destination port |
| rx_ptp_ver | input | 4 | Decoded protocol version |
| rx_msg_type | input | 4 | Decoded message type |
| rd_en | input | 1 | Word read strobe |
| rd_sel | input | 2 | {direction, high word} select |
| rd_data | output | 32 | Registered read data |
| tx_valid | output | 1 | Transmit stamp held |
| rx_valid | output | 1 | Receive stamp held |

## Verification
The delicate case is a high-word read that releases the receive lock in the same cycle as a qualifying receive start-of-frame. The bench first locks the receive stamp. It then raises the high-word read and a matching frame, with a different counter value, on the same falling edge. It judges the result by three observations: the valid flag is low afterwards, the returned high word is the old one, and a following low-word read still returns the original stamp rather than the new counter value.

// File: rtl/ptsl_pkg.sv
`timescale 1ns/1ps
package ptsl_pkg;
  typedef enum logic {
    QUAL_V1_UDP   = 1'b0,
    QUAL_V2_EVENT = 1'b1
  } rx_qual_e;

  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;

  localparam logic [3:0] VER_ONE       = 4'd1;
  localparam logic [3:0] VER_TWO       = 4'd2;
  localparam logic [3:0] EVENT_MSG_MAX = 4'd3;
endpackage

// File: rtl/ptsl_rx_qual.sv
`timescale 1ns/1ps
module ptsl_rx_qual #(
  parameter int PORT_W  = 16,
  parameter int ETYPE_W = 16,
  parameter int MSG_W   = 4,
  parameter int VER_W   = 4
) (
  input  ptsl_pkg::rx_qual_e  mode,
  input  logic [PORT_W-1:0]   cfg_port,
  input  logic [MSG_W-1:0]    cfg_msg,
  input  logic [ETYPE_W-1:0]  flt_etype,
  input  logic                flt_en,
  input  logic                flt_stamp,
  input  logic                is_l2,
  input  logic [ETYPE_W-1:0]  etype,
  input  logic                is_udp,
  input  logic [PORT_W-1:0]   dport,
  input  logic [VER_W-1:0]    ver,
  input  logic [MSG_W-1:0]    msg,
  output logic                match
);
  logic udp_hit;
  logic l2_hit;
  logic v1_hit;
  logic v2_event;

  always_comb begin
    udp_hit  = is_udp && (dport == cfg_port);
    l2_hit   = is_l2 && flt_en && flt_stamp && (etype == flt_etype);
    v1_hit   = udp_hit && (ver == VER_W'(ptsl_pkg::VER_ONE)) && (msg == cfg_msg);
    v2_event = (ver == VER_W'(ptsl_pkg::VER_TWO)) &&
               (msg <= MSG_W'(ptsl_pkg::EVENT_MSG_MAX));
    unique case (mode)
      ptsl_pkg::QUAL_V1_UDP:   match = v1_hit;
      ptsl_pkg::QUAL_V2_EVENT: match = v2_event && (udp_hit || l2_hit);
      default:                 match = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptsl_slot.sv
`timescale 1ns/1ps
module ptsl_slot #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            hit,
  input  logic            rel_i,
  input  logic [TS_W-1:0] time_now,
  output logic            valid,
  output logic [TS_W-1:0] stamp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      stamp <= '0;
    end else if (!en) begin
      valid <= 1'b0;
    end else if (valid) begin
      if (rel_i) valid <= 1'b0;
    end else if (hit) begin
      valid <= 1'b1;
      stamp <= time_now;
    end
  end
endmodule

// File: rtl/ptsl_rd_mux.sv
`timescale 1ns/1ps
module ptsl_rd_mux #(
  parameter int WORD_W = 32,
  parameter int NDIR   = 2,
  localparam int TS_W  = 2 * WORD_W,
  localparam int DIR_W = (NDIR > 1) ? $clog2(NDIR) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic [DIR_W:0]             rd_sel,
  input  logic [NDIR-1:0][TS_W-1:0]  stamps,
  output logic [WORD_W-1:0]          rd_data
);
  logic [DIR_W-1:0] dir;
  logic [TS_W-1:0]  pick;

  always_comb begin
    dir  = rd_sel[DIR_W:1];
    pick = stamps[dir];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_sel[0] ? pick[TS_W-1:WORD_W] : pick[WORD_W-1:0];
    end
  end
endmodule

// File: rtl/ptp_stamp_latch.sv
`timescale 1ns/1ps
module ptp_stamp_latch #(
  parameter int WORD_W  = 32,
  parameter int PORT_W  = 16,
  parameter int ETYPE_W = 16,
  parameter int MSG_W   = 4,
  parameter int VER_W   = 4,
  localparam int TS_W   = 2 * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TS_W-1:0]    time_now,
  input  logic               tx_en,
  input  logic               rx_en,
  input  logic               rx_qual_mode,
  input  logic [PORT_W-1:0]  cfg_event_port,
  input  logic [MSG_W-1:0]   cfg_v1_msg,
  input  logic [ETYPE_W-1:0] l2f_etype,
  input  logic               l2f_en,
  input  logic               l2f_stamp,
  input  logic               tx_sof,
  input  logic               tx_stamp_req,
  input  logic               rx_sof,
  input  logic               rx_is_l2,
  input  logic [ETYPE_W-1:0] rx_ethertype,
  input  logic               rx_is_udp,
  input  logic [PORT_W-1:0]  rx_udp_dport,
  input  logic [VER_W-1:0]   rx_ptp_ver,
  input  logic [MSG_W-1:0]   rx_msg_type,
  input  logic               rd_en,
  input  logic [1:0]         rd_sel,
  output logic [WORD_W-1:0]  rd_data,
  output logic               tx_valid,
  output logic               rx_valid
);
  localparam int NDIR  = 2;
  localparam int DIR_W = 1;

  logic                      rx_match;
  logic [NDIR-1:0]           dir_en;
  logic [NDIR-1:0]           dir_hit;
  logic [NDIR-1:0]           dir_rel;
  logic [NDIR-1:0]           dir_valid;
  logic [NDIR-1:0][TS_W-1:0] dir_stamp;

  ptsl_rx_qual #(
    .PORT_W(PORT_W), .ETYPE_W(ETYPE_W), .MSG_W(MSG_W), .VER_W(VER_W)
  ) u_qual (
    .mode      (ptsl_pkg::rx_qual_e'(rx_qual_mode)),
    .cfg_port  (cfg_event_port),
    .cfg_msg   (cfg_v1_msg),
    .flt_etype (l2f_etype),
    .flt_en    (l2f_en),
    .flt_stamp (l2f_stamp),
    .is_l2     (rx_is_l2),
    .etype     (rx_ethertype),
    .is_udp    (rx_is_udp),
    .dport     (rx_udp_dport),
    .ver       (rx_ptp_ver),
    .msg       (rx_msg_type),
    .match     (rx_match)
  );

  always_comb begin
    dir_en[ptsl_pkg::DIR_TX]  = tx_en;
    dir_en[ptsl_pkg::DIR_RX]  = rx_en;
    dir_hit[ptsl_pkg::DIR_TX] = tx_sof && tx_stamp_req;
    dir_hit[ptsl_pkg::DIR_RX] = rx_sof && rx_match;
  end

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign dir_rel[d] = rd_en && (rd_sel == {DIR_W'(d), 1'b1});

    ptsl_slot #(.TS_W(TS_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .en       (dir_en[d]),
      .hit      (dir_hit[d]),
      .rel_i    (dir_rel[d]),
      .time_now (time_now),
      .valid    (dir_valid[d]),
      .stamp    (dir_stamp[d])
    );
  end

  ptsl_rd_mux #(.WORD_W(WORD_W), .NDIR(NDIR)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .stamps  (dir_stamp),
    .rd_data (rd_data)
  );

  assign tx_valid = dir_valid[ptsl_pkg::DIR_TX];
  assign rx_valid = dir_valid[ptsl_pkg::DIR_RX];
endmodule

// File: rtl/ptp_stamp_latch_chk.sv
`timescale 1ns/1ps
module ptp_stamp_latch_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_en,
  input logic              rx_en,
  input logic              tx_sof,
  input logic              tx_stamp_req,
  input logic              rd_en,
  input logic [1:0]        rd_sel,
  input logic [WORD_W-1:0] rd_data,
  input logic              tx_valid,
  input logic              rx_valid
);
  logic rx_hi_rd;
  logic tx_hi_rd;
  assign rx_hi_rd = rd_en && (rd_sel == 2'b11);
  assign tx_hi_rd = rd_en && (rd_sel == 2'b01);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!tx_valid && !rx_valid && (rd_data == '0)));

  assert_tx_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_sof && tx_stamp_req && tx_en && !tx_valid) |=> tx_valid);

  assert_rx_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_en && !rx_hi_rd) |=> rx_valid);

  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_en && !tx_hi_rd) |=> tx_valid);

  assert_rx_release_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_hi_rd && rx_valid) |=> !rx_valid);

  assert_tx_release_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_hi_rd && tx_valid) |=> !tx_valid);

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  assert_rx_disable_R9: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rx_valid);

  assert_tx_disable_R9: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !tx_valid);

  assert_tx_no_req_R11: assert property (@(posedge clk) disable iff (rst)
    (!tx_valid && !(tx_sof && tx_stamp_req)) |=> !tx_valid);
endmodule

bind ptp_stamp_latch ptp_stamp_latch_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tx_en        (tx_en),
  .rx_en        (rx_en),
  .tx_sof       (tx_sof),
  .tx_stamp_req (tx_stamp_req),
  .rd_en        (rd_en),
  .rd_sel       (rd_sel),
  .rd_data      (rd_data),
  .tx_valid     (tx_valid),
  .rx_valid     (rx_valid)
);

// File: tb/tb_ptp_stamp_latch.sv
`timescale 1ns/1ps
module tb_ptp_stamp_latch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] time_now = '0;
  logic        tx_en = 1'b0, rx_en = 1'b0, rx_qual_mode = 1'b0;
  logic [15:0] cfg_event_port = 16'd319;
  logic [3:0]  cfg_v1_msg = 4'd1;
  logic [15:0] l2f_etype = 16'h88F7;
  logic        l2f_en = 1'b1, l2f_stamp = 1'b1;
  logic        tx_sof = 1'b0, tx_stamp_req = 1'b0, rx_sof = 1'b0;
  logic        rx_is_l2 = 1'b0, rx_is_udp = 1'b0;
  logic [15:0] rx_ethertype = '0, rx_udp_dport = '0;
  logic [3:0]  rx_ptp_ver = '0, rx_msg_type = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        tx_valid, rx_valid;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ptp_stamp_latch dut (
    .clk(clk), .rst(rst), .time_now(time_now), .tx_en(tx_en), .rx_en(rx_en),
    .rx_qual_mode(rx_qual_mode), .cfg_event_port(cfg_event_port),
    .cfg_v1_msg(cfg_v1_msg), .l2f_etype(l2f_etype), .l2f_en(l2f_en),
    .l2f_stamp(l2f_stamp), .tx_sof(tx_sof), .tx_stamp_req(tx_stamp_req),
    .rx_sof(rx_sof), .rx_is_l2(rx_is_l2), .rx_ethertype(rx_ethertype),
    .rx_is_udp(rx_is_udp), .rx_udp_dport(rx_udp_dport),
    .rx_ptp_ver(rx_ptp_ver), .rx_msg_type(rx_msg_type), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd_data), .tx_valid(tx_valid), .rx_valid(rx_valid)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tx_frame(input logic req, input logic [63:0] t);
    @(negedge clk);
    tx_sof = 1'b1; tx_stamp_req = req; time_now = t;
    @(negedge clk);
    tx_sof = 1'b0; tx_stamp_req = 1'b0;
  endtask

  task automatic set_rx(input logic l2, input logic udp, input logic [15:0] et,
                        input logic [15:0] port, input logic [3:0] ver,
                        input logic [3:0] msg, input logic [63:0] t);
    rx_is_l2 = l2; rx_is_udp = udp; rx_ethertype = et; rx_udp_dport = port;
    rx_ptp_ver = ver; rx_msg_type = msg; time_now = t; rx_sof = 1'b1;
  endtask

  task automatic rx_frame(input logic l2, input logic udp, input logic [15:0] et,
                          input logic [15:0] port, input logic [3:0] ver,
                          input logic [3:0] msg, input logic [63:0] t);
    @(negedge clk);
    set_rx(l2, udp, et, port, ver, msg, t);
    @(negedge clk);
    rx_sof = 1'b0;
  endtask

  task automatic read_word(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 tx_valid", 64'(tx_valid), 64'd0);
    chk("R1 rx_valid", 64'(rx_valid), 64'd0);
    chk("R1 rd_data", 64'(rd_data), 64'd0);
    rst = 1'b0; tx_en = 1'b1; rx_en = 1'b1;
  endtask

  task automatic t_tx_basic;
    logic [31:0] d;
    logic [63:0] ta = 64'h1122_3344_5566_7788;
    tx_frame(1'b1, ta);
    chk("R2 tx_valid set", 64'(tx_valid), 64'd1);
    read_word(2'b00, d);
    chk("R5 tx low word", 64'(d), 64'(ta[31:0]));
    chk("R4 low read keeps tx_valid", 64'(tx_valid), 64'd1);
    repeat (2) @(negedge clk);
    chk("R5 rd_data held", 64'(rd_data), 64'(ta[31:0]));
    read_word(2'b01, d);
    chk("R5 tx high word", 64'(d), 64'(ta[63:32]));
    chk("R4 high read clears tx_valid", 64'(tx_valid), 64'd0);
  endtask

  task automatic t_tx_noreq_lock;
    logic [31:0] d;
    tx_frame(1'b0, 64'h0000_0000_0000_00AA);
    chk("R11 no request no stamp", 64'(tx_valid), 64'd0);
    tx_frame(1'b1, 64'hAAAA_0001_BBBB_0002);
    tx_frame(1'b1, 64'hCCCC_0003_DDDD_0004);
    read_word(2'b00, d);
    chk("R3 tx stamp locked", 64'(d), 64'hBBBB_0002);
    read_word(2'b01, d);
    chk("R3 tx high locked", 64'(d), 64'hAAAA_0001);
  endtask

  task automatic t_rx_v1;
    logic [31:0] d;
    rx_qual_mode = 1'b0; cfg_v1_msg = 4'd1;
    rx_frame(1'b0, 1'b1, 16'h0800, 16'd319, 4'd1, 4'd0, 64'h10);
    chk("R6 wrong message type", 64'(rx_valid), 64'd0);
    rx_frame(1'b0, 1'b1, 16'h0800, 16'd320, 4'd1, 4'd1, 64'h11);
    chk("R6 wrong port", 64'(rx_valid), 64'd0);
    rx_frame(1'b0, 1'b1, 16'h0800, 16'd319, 4'd2, 4'd1, 64'h12);
    chk("R6 version 2 in v1 mode", 64'(rx_valid), 64'd0);
    rx_frame(1'b0, 1'b1, 16'h0800, 16'd319, 4'd1, 4'd1, 64'h0102_0304_0506_0708);
    chk("R6 v1 match stamped", 64'(rx_valid), 64'd1);
    read_word(2'b10, d);
    chk("R6 rx low word", 64'(d), 64'h0506_0708);
    read_word(2'b11, d);
    chk("R5 rx high word", 64'(d), 64'h0102_0304);
    chk("R4 rx released", 64'(rx_valid), 64'd0);
  endtask

  task automatic t_rx_v2;
    logic [31:0] d;
    rx_qual_mode = 1'b1;
    rx_frame(1'b0, 1'b1, 16'h0800, 16'd319, 4'd2, 4'd8, 64'h20);
    chk("R7 general message ignored", 64'(rx_valid), 64'd0);
    rx_frame(1'b0, 1'b1, 16'h0800, 16'd319, 4'd2, 4'd3, 64'h0000_0021_0000_0022);
    chk("R7 path-delay over UDP stamped", 64'(rx_valid), 64'd1);
    read_word(2'b10, d);
    chk("R7 udp stamp", 64'(d), 64'h0000_0022);
    read_word(2'b11, d);
    l2f_stamp = 1'b0;
    rx_frame(1'b1, 1'b0, 16'h88F7, 16'd0, 4'd2, 4'd0, 64'h30);
    chk("R8 stamp bit clear", 64'(rx_valid), 64'd0);
    l2f_stamp = 1'b1; l2f_en = 1'b0;
    rx_frame(1'b1, 1'b0, 16'h88F7, 16'd0, 4'd2, 4'd0, 64'h31);
    chk("R8 enable bit clear", 64'(rx_valid), 64'd0);
    l2f_en = 1'b1;
    rx_frame(1'b1, 1'b0, 16'h88F8, 16'd0, 4'd2, 4'd0, 64'h32);
    chk("R7 wrong ethertype", 64'(rx_valid), 64'd0);
    rx_frame(1'b1, 1'b0, 16'h88F7, 16'd0, 4'd2, 4'd2, 64'h0000_0033_0000_0034);
    chk("R7 layer-2 event stamped", 64'(rx_valid), 64'd1);
    rx_frame(1'b1, 1'b0, 16'h88F7, 16'd0, 4'd2, 4'd0, 64'h0000_0099_0000_0098);
    read_word(2'b10, d);
    chk("R3 rx stamp locked", 64'(d), 64'h0000_0034);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    @(negedge clk);
    rd_en = 1'b1; rd_sel = 2'b11;
    set_rx(1'b1, 1'b0, 16'h88F7, 16'd0, 4'd2, 4'd1, 64'h0000_0077_0000_0078);
    @(negedge clk);
    rd_en = 1'b0; rx_sof = 1'b0;
    chk("R10 high word is old", 64'(rd_data), 64'h0000_0033);
    chk("R10 valid low after", 64'(rx_valid), 64'd0);
    read_word(2'b10, d);
    chk("R10 frame not stamped", 64'(d), 64'h0000_0034);
  endtask

  task automatic t_disable;
    rx_frame(1'b0, 1'b1, 16'h0800, 16'd319, 4'd2, 4'd0, 64'h40);
    chk("R9 armed before disable", 64'(rx_valid), 64'd1);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk);
    chk("R9 disable clears rx_valid", 64'(rx_valid), 64'd0);
    rx_frame(1'b0, 1'b1, 16'h0800, 16'd319, 4'd2, 4'd0, 64'h41);
    chk("R9 no stamp while disabled", 64'(rx_valid), 64'd0);
    tx_frame(1'b1, 64'h50);
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk);
    chk("R9 disable clears tx_valid", 64'(tx_valid), 64'd0);
    rx_en = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_tx_basic();
    t_tx_noreq_lock();
    t_rx_v1();
    t_rx_v2();
    t_collision();
    t_disable();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule